// File: doc/BRIEF.md
# Peripheral DMA Control Register File

This block is the software-facing control and status front end of a DMA engine that moves data between local memory and a 16-bit external peripheral bus. Software sees a 32-bit register port addressed by byte offset. Through it, software loads a memory address and a bus address. Writing one of two length registers launches a transfer: one register moves data from memory to the bus, the other moves data from the bus to memory. The block passes a one-cycle start pulse, the direction, both addresses and the length to a transfer sequencer. That sequencer lies outside this block.

Two banks of bus timing parameters are held: address-to-strobe latency, strobe width, page size and release time. The bank whose values reach the sequencer is chosen from the bus address by a fixed map. The sequencer reports completion and errors back. The block turns these reports into busy, error and interrupt status. It also offers a soft reset that aborts the transfer in flight.

A two-state controller drives the transfer status. In state `ST_IDLE`, a write to a length register makes the transition *launch* to `ST_RUN` and raises the start pulse. In `ST_RUN`, a completion report makes the transition *finish* back to `ST_IDLE` and raises the interrupt. In either state, a soft reset makes the transition *abort* to `ST_IDLE`.

Top module: `xfer_ctl_regfile`

## Requirements
- R1: Byte offset 0x00 holds a 24-bit memory address and offset 0x04 holds a 32-bit bus address. Both read back as written, except that bit 0 always reads as 0.
- R2: A write to offset 0x08 (memory to bus, `seq_dir`=0) or to offset 0x0C (bus to memory, `seq_dir`=1) while idle has three effects. It loads `seq_len` with the low 24 bits of the write data, sets `seq_dir`, and raises `seq_start` high for exactly the one cycle after the write. Reading either offset returns 0x0000007F.
- R3: Status is read at offset 0x10. Bit 0 (DMA busy) reads 1 from the cycle after a length write until the cycle after `seq_done` is seen while busy. A `seq_done` pulse seen while idle changes nothing.
- R4: Status bit 3 (interrupt) is set in the same cycle that busy clears on completion. Writing status with bit 1 set clears it. The `irq` output always equals status bit 3.
- R5: A length write made while busy leaves `seq_len`, `seq_dir` and the transfer unchanged, gives no start pulse, and sets status bit 2 (error). A `seq_error` pulse seen while busy also sets bit 2.
- R6: Writing status with bit 0 set is a soft reset. It raises `seq_abort` for the following cycle and clears busy and error. It leaves the interrupt bit as it is.
- R7: Timing bank 1 sits at 0x14 (latency, 8 bits), 0x18 (pulse width, 8 bits), 0x1C (page size, 4 bits) and 0x20 (release, 2 bits). Bank 2 uses 0x24, 0x28, 0x2C and 0x30 in the same order. Unused upper bits read 0.
- R8: Bus addresses 0x0500_0000..0x05FF_FFFF and 0x0800_0000..0x0FFF_FFFF drive bank 2 onto the `seq_latency`, `seq_pulse`, `seq_page` and `seq_release` outputs. Every other bus address drives bank 1.
- R9: After reset, every register reads 0, `irq` is 0 and no transfer is active.
- R10: Status bit 1 (I/O busy) reflects the `io_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_offs | input | 6 | Register byte offset (bits 1:0 ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_offs` (combinational) |
| seq_start | output | 1 | One-cycle transfer launch pulse |
| seq_dir | output | 1 | 0 = memory to bus, 1 = bus to memory |
| seq_mem_addr | output | 24 | Memory address |
| seq_bus_addr | output | 32 | Bus address |
| seq_len | output | 24 | Byte count minus one |
| seq_latency | output | 8 | Selected bank latency |
| seq_pulse | output | 8 | Selected bank strobe width |
| seq_page | output | 4 | Selected bank page size code |
| seq_release | output | 2 | Selected bank release time |
| seq_abort | output | 1 | Soft-reset pulse to the sequencer |
| seq_done | input | 1 | Transfer finished |
| seq_error | input | 1 | Transfer fault |
| io_busy | input | 1 | Direct I/O access in progress |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with its default widths: a 24-bit memory address and length, a 32-bit bus address, and the length readback value 0x7F. With these widths, the real bus map boundaries can be probed exactly. The probes are the last even address below and the first address of each bank-2 window, and the last even address of each window and the first address after it. The full 24-bit length field carries values that show the busy-time write being discarded.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    localparam int W_MEM_ADDR = 0;
    localparam int W_BUS_ADDR = 1;
    localparam int W_LEN_OUT  = 2;
    localparam int W_LEN_IN   = 3;
    localparam int W_STATUS   = 4;
    localparam int W_BANK0    = 5;
    localparam int BANK_WORDS = 4;

    typedef struct packed {
        logic [7:0] lat;
        logic [7:0] pwd;
        logic [3:0] pgs;
        logic [1:0] rls;
    } bank_t;

endpackage

// File: rtl/xfer_timing_bank.sv
module xfer_timing_bank
    import xfer_ctl_pkg::*;
#(
    parameter int BASE_WORD = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wen,
    input  logic [3:0]  word,
    input  logic [31:0] wdata,
    output bank_t       bank
);
    localparam logic [3:0] W_LAT = 4'(BASE_WORD);
    localparam logic [3:0] W_PWD = 4'(BASE_WORD + 1);
    localparam logic [3:0] W_PGS = 4'(BASE_WORD + 2);
    localparam logic [3:0] W_RLS = 4'(BASE_WORD + 3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (wen) begin
            if (word == W_LAT) bank.lat <= wdata[7:0];
            if (word == W_PWD) bank.pwd <= wdata[7:0];
            if (word == W_PGS) bank.pgs <= wdata[3:0];
            if (word == W_RLS) bank.rls <= wdata[1:0];
        end
    end
endmodule

// File: rtl/xfer_bank_select.sv
module xfer_bank_select #(
    parameter int BUS_AW = 32
) (
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              use_bank2
);
    localparam int TOP = BUS_AW - 1;

    logic win_a;
    logic win_b;

    always_comb begin
        win_a     = (bus_addr[TOP -: 8] == 8'h05);
        win_b     = (bus_addr[TOP -: 5] == 5'b00001);
        use_bank2 = win_a | win_b;
    end
endmodule

// File: rtl/xfer_ctl_fsm.sv
module xfer_ctl_fsm
    import xfer_ctl_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic             len_dir,
    input  logic [LEN_W-1:0] len_val,
    input  logic             stat_wr,
    input  logic [1:0]       stat_bits,
    input  logic             seq_done,
    input  logic             seq_error,
    output logic             seq_start,
    output logic             seq_dir,
    output logic [LEN_W-1:0] seq_len,
    output logic             seq_abort,
    output logic             busy,
    output logic             err,
    output logic             irq
);
    ctl_state_t state, state_nx;
    logic abort_req;
    logic irq_clr;
    logic launch;
    logic finish;

    always_comb begin
        abort_req = stat_wr & stat_bits[0];
        irq_clr   = stat_wr & stat_bits[1];
        launch    = 1'b0;
        finish    = 1'b0;
        state_nx  = state;
        unique case (state)
            ST_IDLE: begin
                if (len_wr) begin
                    launch   = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                if (abort_req) begin
                    state_nx = ST_IDLE;
                end else if (seq_done) begin
                    finish   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_start <= 1'b0;
            seq_dir   <= 1'b0;
            seq_len   <= '0;
            seq_abort <= 1'b0;
            err       <= 1'b0;
            irq       <= 1'b0;
        end else begin
            seq_start <= launch;
            seq_abort <= abort_req;
            if (launch) begin
                seq_dir <= len_dir;
                seq_len <= len_val;
            end
            if (abort_req)
                err <= 1'b0;
            else if (state == ST_RUN && (len_wr || seq_error))
                err <= 1'b1;
            if (finish)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

    assign busy = (state == ST_RUN);

    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);
    p_busy_write_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && len_wr && !abort_req) |=> (err && !seq_start && $stable(seq_len)));
    p_finish_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_done && !abort_req) |=> (irq && !busy));
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!busy && !err && seq_abort));
    p_idle_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && seq_done && !len_wr) |=> (!busy && $stable(irq) || $past(irq_clr)));
endmodule

// File: rtl/xfer_ctl_regfile.sv
module xfer_ctl_regfile
    import xfer_ctl_pkg::*;
#(
    parameter int          MEM_AW   = 24,
    parameter int          BUS_AW   = 32,
    parameter int          LEN_W    = 24,
    parameter logic [31:0] LEN_READ = 32'h0000_007F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [5:0]        reg_offs,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              seq_start,
    output logic              seq_dir,
    output logic [MEM_AW-1:0] seq_mem_addr,
    output logic [BUS_AW-1:0] seq_bus_addr,
    output logic [LEN_W-1:0]  seq_len,
    output logic [7:0]        seq_latency,
    output logic [7:0]        seq_pulse,
    output logic [3:0]        seq_page,
    output logic [1:0]        seq_release,
    output logic              seq_abort,
    input  logic              seq_done,
    input  logic              seq_error,
    input  logic              io_busy,
    output logic              irq
);
    localparam int NBANK = 2;

    logic [3:0] word;
    bank_t      banks [NBANK];
    bank_t      sel_bank;
    logic       use_bank2;
    logic       busy;
    logic       err;
    logic       len_wr;
    logic       stat_wr;

    assign word    = reg_offs[5:2];
    assign len_wr  = reg_wen && (word == 4'(W_LEN_OUT) || word == 4'(W_LEN_IN));
    assign stat_wr = reg_wen && (word == 4'(W_STATUS));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_mem_addr <= '0;
            seq_bus_addr <= '0;
        end else if (reg_wen) begin
            if (word == 4'(W_MEM_ADDR))
                seq_mem_addr <= {reg_wdata[MEM_AW-1:1], 1'b0};
            if (word == 4'(W_BUS_ADDR))
                seq_bus_addr <= {reg_wdata[BUS_AW-1:1], 1'b0};
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        xfer_timing_bank #(.BASE_WORD(W_BANK0 + g * BANK_WORDS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wen   (reg_wen),
            .word  (word),
            .wdata (reg_wdata),
            .bank  (banks[g])
        );
    end

    xfer_bank_select #(.BUS_AW(BUS_AW)) u_sel (
        .bus_addr  (seq_bus_addr),
        .use_bank2 (use_bank2)
    );

    assign sel_bank    = use_bank2 ? banks[1] : banks[0];
    assign seq_latency = sel_bank.lat;
    assign seq_pulse   = sel_bank.pwd;
    assign seq_page    = sel_bank.pgs;
    assign seq_release = sel_bank.rls;

    xfer_ctl_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_wr    (len_wr),
        .len_dir   (word == 4'(W_LEN_IN)),
        .len_val   (reg_wdata[LEN_W-1:0]),
        .stat_wr   (stat_wr),
        .stat_bits (reg_wdata[1:0]),
        .seq_done  (seq_done),
        .seq_error (seq_error),
        .seq_start (seq_start),
        .seq_dir   (seq_dir),
        .seq_len   (seq_len),
        .seq_abort (seq_abort),
        .busy      (busy),
        .err       (err),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (word)
            4'(W_MEM_ADDR): reg_rdata = 32'(seq_mem_addr);
            4'(W_BUS_ADDR): reg_rdata = 32'(seq_bus_addr);
            4'(W_LEN_OUT),
            4'(W_LEN_IN):   reg_rdata = LEN_READ;
            4'(W_STATUS):   reg_rdata = {28'b0, irq, err, io_busy, busy};
            default: begin
                for (int b = 0; b < NBANK; b++) begin
                    if (word == 4'(W_BANK0 + b * BANK_WORDS))     reg_rdata = 32'(banks[b].lat);
                    if (word == 4'(W_BANK0 + b * BANK_WORDS + 1)) reg_rdata = 32'(banks[b].pwd);
                    if (word == 4'(W_BANK0 + b * BANK_WORDS + 2)) reg_rdata = 32'(banks[b].pgs);
                    if (word == 4'(W_BANK0 + b * BANK_WORDS + 3)) reg_rdata = 32'(banks[b].rls);
                end
            end
        endcase
    end

    p_addr_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_mem_addr[0] && !seq_bus_addr[0]);
    p_bank2_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_bus_addr[BUS_AW-1 -: 8] == 8'h05) |-> (seq_latency == banks[1].lat && seq_page == banks[1].pgs));
    p_bank1_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_bus_addr[BUS_AW-1 -: 8] < 8'h05) |-> (seq_pulse == banks[0].pwd && seq_release == banks[0].rls));
endmodule

// File: tb/xfer_ctl_regfile_bench.sv
`timescale 1ns/1ps
module xfer_ctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [5:0]  reg_offs = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_start, seq_dir, seq_abort, irq;
    logic [23:0] seq_mem_addr, seq_len;
    logic [31:0] seq_bus_addr;
    logic [7:0]  seq_latency, seq_pulse;
    logic [3:0]  seq_page;
    logic [1:0]  seq_release;
    logic        seq_done = 1'b0, seq_error = 1'b0, io_busy = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xfer_ctl_regfile u_xfer_ctl_regfile (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_offs(reg_offs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_start(seq_start),
        .seq_dir(seq_dir), .seq_mem_addr(seq_mem_addr), .seq_bus_addr(seq_bus_addr),
        .seq_len(seq_len), .seq_latency(seq_latency), .seq_pulse(seq_pulse),
        .seq_page(seq_page), .seq_release(seq_release), .seq_abort(seq_abort),
        .seq_done(seq_done), .seq_error(seq_error), .io_busy(io_busy), .irq(irq)
    );

    // behavioural reference model
    int m_mem, m_bus, m_len;
    int m_lat[2], m_pwd[2], m_pgs[2], m_rls[2];
    bit m_dir, m_busy, m_err, m_irq, m_start, m_abort;

    always @(posedge clk) begin
        int w;
        bit ab;
        w  = reg_offs / 4;
        ab = reg_wen && w == 4 && reg_wdata[0];
        if (!rst_n) begin
            m_mem <= 0; m_bus <= 0; m_len <= 0; m_dir <= 0; m_busy <= 0;
            m_err <= 0; m_irq <= 0; m_start <= 0; m_abort <= 0;
            for (int b = 0; b < 2; b++) begin
                m_lat[b] <= 0; m_pwd[b] <= 0; m_pgs[b] <= 0; m_rls[b] <= 0;
            end
        end else begin
            m_start <= 0;
            m_abort <= ab;
            if (reg_wen && w == 0) m_mem <= int'(reg_wdata & 32'h00FF_FFFE);
            if (reg_wen && w == 1) m_bus <= int'(reg_wdata & 32'hFFFF_FFFE);
            if (reg_wen && w >= 5 && w <= 12) begin
                case ((w - 5) % 4)
                    0: m_lat[(w - 5) / 4] <= int'(reg_wdata % 256);
                    1: m_pwd[(w - 5) / 4] <= int'(reg_wdata % 256);
                    2: m_pgs[(w - 5) / 4] <= int'(reg_wdata % 16);
                    default: m_rls[(w - 5) / 4] <= int'(reg_wdata % 4);
                endcase
            end
            if (reg_wen && (w == 2 || w == 3)) begin
                if (m_busy) begin
                    m_err <= 1;
                end else begin
                    m_busy <= 1; m_start <= 1; m_dir <= (w == 3);
                    m_len <= int'(reg_wdata & 32'h00FF_FFFF);
                end
            end
            if (m_busy && seq_error && !ab) m_err <= 1;
            if (ab) begin
                m_busy <= 0; m_err <= 0;
            end else if (m_busy && seq_done) begin
                m_busy <= 0;
            end
            if (m_busy && seq_done && !ab) m_irq <= 1;
            else if (reg_wen && w == 4 && reg_wdata[1]) m_irq <= 0;
        end
    end

    function automatic bit bank2(input int a);
        int top;
        top = (a >> 24) & 255;
        return top == 5 || (top >= 8 && top <= 15);
    endfunction

    function automatic int exp_rd(input int w);
        case (w)
            0: return m_mem;
            1: return m_bus;
            2, 3: return 32'h7F;
            4: return {28'b0, m_irq, m_err, io_busy, m_busy};
            5, 9: return m_lat[(w - 5) / 4];
            6, 10: return m_pwd[(w - 5) / 4];
            7, 11: return m_pgs[(w - 5) / 4];
            8, 12: return m_rls[(w - 5) / 4];
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            int w;
            int bi;
            w  = reg_offs / 4;
            bi = bank2(m_bus) ? 1 : 0;
            chk("R1 mem addr", seq_mem_addr, m_mem);
            chk("R1 bus addr", seq_bus_addr, m_bus);
            chk("R2 start", seq_start, m_start);
            chk("R2 dir", seq_dir, m_dir);
            chk("R2 len", seq_len, m_len);
            chk("R4 irq", irq, m_irq);
            chk("R6 abort", seq_abort, m_abort);
            chk("R8 latency", seq_latency, m_lat[bi]);
            chk("R8 pulse", seq_pulse, m_pwd[bi]);
            chk("R8 page", seq_page, m_pgs[bi]);
            chk("R8 release", seq_release, m_rls[bi]);
            chk(w == 4 ? "R3 status read" : (w >= 5 ? "R7 bank read" : "R1 R2 reg read"),
                reg_rdata, exp_rd(w));
        end
    end

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1; reg_offs = 6'(w * 4); reg_wdata = d;
        @(negedge clk);
        reg_wen = 0;
    endtask

    task automatic rd_check(input int w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_offs = 6'(w * 4);
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_in(input bit is_err);
        @(negedge clk);
        if (is_err) seq_error = 1; else seq_done = 1;
        @(negedge clk);
        seq_done = 0; seq_error = 0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int addrs[8] = '{32'h04FF_FFFE, 32'h0500_0000, 32'h05FF_FFFE, 32'h0600_0000,
                         32'h07FF_FFFE, 32'h0800_0000, 32'h0FFF_FFFE, 32'h1000_0000};
        bit   b2[8]  = '{0, 1, 1, 0, 0, 1, 1, 0};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        rd_check(0, 0, "R9 mem addr");
        rd_check(1, 0, "R9 bus addr");
        rd_check(4, 0, "R9 status");
        rd_check(5, 0, "R9 bank lat");
        chk("R9 irq", irq, 0);
        // R1
        wr(0, 32'hFFAB_CDEF);
        wr(1, 32'h1000_1001);
        rd_check(0, 32'h00AB_CDEE, "R1 mem addr lsb");
        rd_check(1, 32'h1000_1000, "R1 bus addr lsb");
        // R7
        wr(5, 32'h141); wr(6, 32'h12); wr(7, 32'hFF); wr(8, 32'hFF);
        wr(9, 32'h22);  wr(10, 32'h33); wr(11, 32'h5); wr(12, 32'h2);
        rd_check(5, 32'h41, "R7 lat1 width");
        rd_check(7, 32'hF, "R7 pgs1 width");
        rd_check(8, 32'h3, "R7 rls1 width");
        rd_check(12, 32'h2, "R7 rls2");
        // R8 map boundaries
        for (int i = 0; i < 8; i++) begin
            wr(1, addrs[i]);
            chk("R8 map latency", seq_latency, b2[i] ? 8'h22 : 8'h41);
            chk("R8 map page", seq_page, b2[i] ? 4'h5 : 4'hF);
        end
        // R2 launch
        wr(1, 32'h1000_1000);
        wr(2, 32'h0000_007F);
        rd_check(2, 32'h7F, "R2 len read");
        rd_check(4, 32'h1, "R3 busy");
        chk("R2 len", seq_len, 24'h7F);
        chk("R2 dir", seq_dir, 0);
        // R5 write while busy
        wr(3, 32'h0012_3456);
        rd_check(4, 32'h5, "R5 error set");
        chk("R5 len kept", seq_len, 24'h7F);
        chk("R5 dir kept", seq_dir, 0);
        // R4 completion
        pulse_in(0);
        rd_check(4, 32'hC, "R4 irq set");
        chk("R4 irq port", irq, 1);
        wr(4, 32'h2);
        rd_check(4, 32'h4, "R4 irq cleared");
        chk("R4 irq port low", irq, 0);
        // R3 done while idle ignored
        pulse_in(0);
        rd_check(4, 32'h4, "R3 idle done ignored");
        // R6 soft reset clears error
        wr(4, 32'h1);
        rd_check(4, 32'h0, "R6 soft reset");
        // R2 other direction, R5 error input, R6 abort mid transfer
        wr(3, 32'h00FF_01FF);
        chk("R2 len in", seq_len, 24'hFF01FF);
        chk("R2 dir in", seq_dir, 1);
        pulse_in(1);
        rd_check(4, 32'h5, "R5 seq_error");
        wr(4, 32'h1);
        rd_check(4, 32'h0, "R6 abort");
        chk("R6 no irq", irq, 0);
        // R10
        io_busy = 1;
        rd_check(4, 32'h2, "R10 io busy");
        io_busy = 0;
        rd_check(4, 32'h0, "R10 io idle");
        repeat (4) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule